// File: doc/BRIEF.md
# Core Countdown Tick Timer

A 32-bit down-counting timer sitting next to a processor core. Software programs it through four word-wide registers reached over a small request port: a control word, a reload period, a prescale value and the live count. Once power and enable are both set, the count drops by the effective step on every clock. When the remaining count would reach zero, the timer latches a sticky flag and emits a single-cycle interrupt pulse.

After an expiry the timer either reloads the period and keeps going, or it parks at zero and waits to be re-armed. A re-arm is a fresh transition of the power-and-enable condition from false to true. Register accesses are answered one cycle after the request, with read data and a two-bit error code.

Top module: `core_tick_timer`

## Requirements
- R1: Registers live at byte offsets 0x0 control, 0x4 period, 0x8 scale, 0xC count, are 32 bits wide, and read as zero after reset. A request issued in one cycle has its read data and error code on `rsp_rdata`/`rsp_err` in the next cycle.
- R2: Counting happens only while control bit 0 (power) and bit 1 (enable) are both 1. With either bit clear the count holds and no interrupt is raised.
- R3: The step per clock is scale bits [7:0] plus one, giving 1 to 256. Scale bits [31:8] are stored and read back unchanged but have no effect.
- R4: From a count C with step S, expiry occurs on the ceil(C/S)-th clock after arming, and on the first clock when C is 0. While running the count strictly decreases and never wraps below zero.
- R5: Each expiry sets control bit 3 (flag) and drives `irq_pulse` high for exactly that one expiry cycle.
- R6: With control bit 2 (auto-reload) set, an expiry loads the period into the count and counting continues with the same interval.
- R7: Without auto-reload, an expiry forces the count to 0 and the timer stays idle, even after a new count is written. It restarts only when power-and-enable goes from false to true.
- R8: A write to the period also writes the same value into the count.
- R9: A control write replaces the register directly. Writing 0 to bit 3 clears the flag and writing 1 sets it without any interrupt pulse. Control bits [31:4] always read as zero.
- R10: Writes to count and period take effect while the timer is running. Counting continues from the written value.
- R11: `req_size` encodes 0 byte, 1 halfword, 2 word, 3 reserved. Any size other than word is rejected with `rsp_err` = 1 and changes no register. This takes priority over an offset error.
- R12: A word access at an offset that is not one of the four registers returns `rsp_err` = 2, changes nothing, and reads as zero.
- R13: A scale write while running applies from the current remaining count, without restarting it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | Access size code (2 = word) |
| req_addr | input | 4 | Byte offset within the block |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| rsp_err | output | 2 | 0 ok, 1 size error, 2 offset error |
| irq_pulse | output | 1 | One-cycle interrupt on expiry |

## Verification
Every cycle, the assertions check the following: an interrupt pulse is always paired with a set flag; the count stays frozen while power or enable is off; a running count strictly drops until its last step; a period write lands in the count; and a non-word write leaves period and scale untouched with a size error. Only the bench scenarios can show the rest. That covers the exact expiry cycle against ceil(C/S) across a sweep of counts and scales, the auto-reload interval, re-arming after a stop, mid-run count, period and scale writes, and the precedence between the two error codes.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_SIZE = 2'd1,
        ERR_ADDR = 2'd2
    } acc_err_e;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_SCALE  = 2'd2,
        SEL_COUNT  = 2'd3
    } reg_sel_e;

    localparam int NUM_REGS  = 4;
    localparam int CTRL_BITS = 4;

    // packed from msb: flag(3) reload(2) enable(1) power(0)
    typedef struct packed {
        logic flag;
        logic reload;
        logic enable;
        logic power;
    } ctrl_t;

    function automatic logic ctrl_active(input ctrl_t c);
        return c.power & c.enable;
    endfunction

endpackage

// File: rtl/ctmr_decode.sv
module ctmr_decode
    import ctmr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic [NUM_REGS-1:0] wr_vec,
    output logic                rd_en,
    output reg_sel_e            sel,
    output acc_err_e            err
);
    logic upper_zero;
    logic size_ok;
    logic offs_ok;

    generate
        if (ADDR_W > 4) begin : g_wide
            assign upper_zero = ~|req_addr[ADDR_W-1:4];
        end else begin : g_narrow
            assign upper_zero = 1'b1;
        end
    endgenerate

    assign size_ok = (acc_size_e'(req_size) == SZ_WORD);
    assign offs_ok = upper_zero && (req_addr[1:0] == 2'b00);
    assign sel     = reg_sel_e'(req_addr[3:2]);

    always_comb begin
        if (!size_ok)      err = ERR_SIZE;
        else if (!offs_ok) err = ERR_ADDR;
        else               err = ERR_NONE;
    end

    assign rd_en = req_valid && !req_write && (err == ERR_NONE);

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_wr
            assign wr_vec[g] = req_valid && req_write && (err == ERR_NONE)
                               && (sel == reg_sel_e'(g));
        end
    endgenerate

endmodule

// File: rtl/ctmr_count.sv
module ctmr_count #(
    parameter int DATA_W     = 32,
    parameter int SCALE_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic                  reload,
    input  logic [SCALE_BITS:0]   step,
    input  logic [DATA_W-1:0]     period,
    input  logic                  load_en,
    input  logic [DATA_W-1:0]     load_val,
    output logic [DATA_W-1:0]     count,
    output logic                  expire
);
    logic [DATA_W-1:0] step_w;

    assign step_w = DATA_W'(step);
    assign expire = run && (count <= step_w);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load_en) begin
            count <= load_val;
        end else if (expire) begin
            count <= reload ? period : '0;
        end else if (run) begin
            count <= count - step_w;
        end
    end

endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
    import ctmr_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int SCALE_BITS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [1:0]        rsp_err,
    output logic              irq_pulse
);
    localparam int STEP_W = SCALE_BITS + 1;

    ctrl_t               ctrl_q;
    ctrl_t               ctrl_wr;
    logic [DATA_W-1:0]   period_q;
    logic [DATA_W-1:0]   scale_q;
    logic [DATA_W-1:0]   count_q;
    logic                armed_q;
    logic                irq_q;
    logic [DATA_W-1:0]   rdata_q;
    acc_err_e            err_q;

    logic [NUM_REGS-1:0] wr_vec;
    logic                rd_en;
    reg_sel_e            sel;
    acc_err_e            err;

    logic                active_now;
    logic                active_next;
    logic                running;
    logic                expire;
    logic                load_en;
    logic [STEP_W-1:0]   step;

    ctmr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .wr_vec    (wr_vec),
        .rd_en     (rd_en),
        .sel       (sel),
        .err       (err)
    );

    assign ctrl_wr     = ctrl_t'(req_wdata[CTRL_BITS-1:0]);
    assign active_now  = ctrl_active(ctrl_q);
    assign active_next = wr_vec[SEL_CTRL] ? ctrl_active(ctrl_wr) : active_now;
    assign running     = active_now && armed_q;
    assign step        = {1'b0, scale_q[SCALE_BITS-1:0]} + STEP_W'(1);
    assign load_en     = wr_vec[SEL_COUNT] | wr_vec[SEL_PERIOD];

    ctmr_count #(.DATA_W(DATA_W), .SCALE_BITS(SCALE_BITS)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (running),
        .reload   (ctrl_q.reload),
        .step     (step),
        .period   (period_q),
        .load_en  (load_en),
        .load_val (req_wdata),
        .count    (count_q),
        .expire   (expire)
    );

    // control register and arming state
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            armed_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (wr_vec[SEL_CTRL]) begin
                ctrl_q <= ctrl_wr;
            end
            if (expire) begin
                ctrl_q.flag <= 1'b1;
            end
            if (!active_next) begin
                armed_q <= 1'b0;
            end else if (!active_now) begin
                armed_q <= 1'b1;
            end else if (expire && !ctrl_q.reload) begin
                armed_q <= 1'b0;
            end
            irq_q <= expire;
        end
    end

    // period and scale storage
    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
            scale_q  <= '0;
        end else begin
            if (wr_vec[SEL_PERIOD]) period_q <= req_wdata;
            if (wr_vec[SEL_SCALE])  scale_q  <= req_wdata;
        end
    end

    // response path
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            err_q   <= ERR_NONE;
        end else begin
            err_q <= req_valid ? err : ERR_NONE;
            if (rd_en) begin
                case (sel)
                    SEL_CTRL:   rdata_q <= DATA_W'(ctrl_q);
                    SEL_PERIOD: rdata_q <= period_q;
                    SEL_SCALE:  rdata_q <= scale_q;
                    default:    rdata_q <= count_q;
                endcase
            end else begin
                rdata_q <= '0;
            end
        end
    end

    assign rsp_rdata = rdata_q;
    assign rsp_err   = err_q;
    assign irq_pulse = irq_q;

endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk #(
    parameter int DATA_W     = 32,
    parameter int SCALE_BITS = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic                  req_write,
    input logic [1:0]            req_size,
    input logic [1:0]            rsp_err,
    input logic                  irq_pulse,
    input logic [3:0]            ctrl_bits,
    input logic [DATA_W-1:0]     count_q,
    input logic [DATA_W-1:0]     period_q,
    input logic [DATA_W-1:0]     scale_q,
    input logic [SCALE_BITS:0]   step,
    input logic                  running,
    input logic [3:0]            wr_vec
);
    logic loading;
    assign loading = wr_vec[1] | wr_vec[3];

    // R5
    irq_has_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> ctrl_bits[3]);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(ctrl_bits[0] && ctrl_bits[1]) && !loading)
        |=> ($stable(count_q) && !irq_pulse));

    // R4
    count_falls_chk: assert property (@(posedge clk) disable iff (rst)
        (running && !loading && (count_q > DATA_W'(step)))
        |=> (count_q < $past(count_q)));

    // R8
    period_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        wr_vec[1] |=> (count_q == period_q));

    // R11
    size_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_size != 2'd2)
        |=> ($stable(period_q) && $stable(scale_q) && rsp_err == 2'd1));

endmodule

bind core_tick_timer ctmr_chk #(.DATA_W(DATA_W), .SCALE_BITS(SCALE_BITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .rsp_err   (rsp_err),
    .irq_pulse (irq_pulse),
    .ctrl_bits (ctrl_q),
    .count_q   (count_q),
    .period_q  (period_q),
    .scale_q   (scale_q),
    .step      (step),
    .running   (running),
    .wr_vec    (wr_vec)
);

// File: tb/core_tick_timer_test.sv
module core_tick_timer_test;

    localparam logic [3:0] A_CTRL = 4'h0, A_PER = 4'h4, A_SCL = 4'h8, A_CNT = 4'hC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd2;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic [1:0]  rsp_err;
    logic        irq_pulse;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    core_tick_timer uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq_pulse(irq_pulse)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [1:0] sz,
                      output logic [1:0] e);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_size = sz;
        @(negedge clk);
        e = rsp_err;
        req_valid = 1'b0; req_write = 1'b0; req_size = 2'd2;
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] sz,
                      output logic [31:0] d, output logic [1:0] e);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
        @(negedge clk);
        d = rsp_rdata; e = rsp_err;
        req_valid = 1'b0; req_size = 2'd2;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq_pulse && n < 2000);
    endtask

    task automatic quiet(input int k, output logic seen);
        seen = 1'b0;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            if (irq_pulse) seen = 1'b1;
        end
    endtask

    initial begin
        logic [31:0] d;
        logic [1:0]  e;
        logic        seen;
        int          n;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq after reset", {31'b0, irq_pulse}, 0);
        chk("R1 err after reset", {30'b0, rsp_err}, 0);
        for (int i = 0; i < 4; i++) begin
            rd(4'(i * 4), 2'd2, d, e);
            chk("R1 reset read", d, 0);
        end

        // R9 control upper bits and flag write
        wr(A_CTRL, 32'hFFFF_FFF0, 2'd2, e);
        rd(A_CTRL, 2'd2, d, e);
        chk("R9 upper ctrl bits read zero", d, 0);
        wr(A_CTRL, 32'h8, 2'd2, e);
        quiet(5, seen);
        chk("R9 flag write no pulse", {31'b0, seen}, 0);
        rd(A_CTRL, 2'd2, d, e);
        chk("R9 flag set by write", d, 32'h8);
        wr(A_CTRL, 32'h0, 2'd2, e);
        rd(A_CTRL, 2'd2, d, e);
        chk("R9 flag cleared by write", d, 0);

        // R3 stored scale
        wr(A_SCL, 32'h1234_5603, 2'd2, e);
        rd(A_SCL, 2'd2, d, e);
        chk("R3 scale stored", d, 32'h1234_5603);

        // R8 mirror
        wr(A_PER, 32'h77, 2'd2, e);
        rd(A_CNT, 2'd2, d, e);
        chk("R8 period mirrored to count", d, 32'h77);
        rd(A_PER, 2'd2, d, e);
        chk("R1 period readback", d, 32'h77);

        // R11 size errors
        wr(A_PER, 32'h55, 2'd1, e);
        chk("R11 halfword error code", {30'b0, e}, 1);
        rd(A_PER, 2'd2, d, e);
        chk("R11 period unchanged", d, 32'h77);
        wr(4'h5, 32'h1, 2'd0, e);
        chk("R11 size beats offset", {30'b0, e}, 1);
        rd(A_SCL, 2'd3, d, e);
        chk("R11 reserved size read", {30'b0, e}, 1);
        rd(A_CTRL, 2'd2, d, e);
        chk("R11 ctrl unchanged", d, 0);

        // R12 offset errors
        wr(4'h6, 32'hFF, 2'd2, e);
        chk("R12 offset error code", {30'b0, e}, 2);
        rd(4'h2, 2'd2, d, e);
        chk("R12 offset read error", {30'b0, e}, 2);
        chk("R12 offset read data", d, 0);
        rd(A_SCL, 2'd2, d, e);
        chk("R12 scale unchanged", d, 32'h1234_5603);

        // R2 power or enable alone
        wr(A_CTRL, 32'h0, 2'd2, e);
        wr(A_SCL, 32'h0, 2'd2, e);
        wr(A_PER, 32'd5, 2'd2, e);
        wr(A_CTRL, 32'h2, 2'd2, e);
        quiet(20, seen);
        chk("R2 enable only no irq", {31'b0, seen}, 0);
        wr(A_CTRL, 32'h1, 2'd2, e);
        quiet(20, seen);
        chk("R2 power only no irq", {31'b0, seen}, 0);
        rd(A_CNT, 2'd2, d, e);
        chk("R2 count held", d, 5);

        // R4 R5 R7 R3 sweep over count and scale
        for (int c = 0; c <= 20; c++) begin
            for (int s = 0; s < 8; s++) begin
                int eff;
                int expn;
                eff  = s + 1;
                expn = (c == 0) ? 1 : (c + eff - 1) / eff;
                wr(A_CTRL, 32'h0, 2'd2, e);
                wr(A_SCL, 32'(s) | ((c % 2 == 1) ? 32'h5A00 : 32'h0), 2'd2, e);
                wr(A_PER, 32'(c), 2'd2, e);
                wr(A_CTRL, 32'h3, 2'd2, e);
                wait_irq(n);
                chk($sformatf("R4 expiry clocks c=%0d s=%0d", c, s), 32'(n), 32'(expn));
                @(negedge clk);
                chk("R5 pulse lasts one cycle", {31'b0, irq_pulse}, 0);
                rd(A_CNT, 2'd2, d, e);
                chk("R7 count parked at zero", d, 0);
                rd(A_CTRL, 2'd2, d, e);
                chk("R5 flag set on expiry", d, 32'hB);
            end
        end

        // R7 stays idle, re-arms on enable edge
        quiet(10, seen);
        chk("R7 idle after stop", {31'b0, seen}, 0);
        wr(A_SCL, 32'h0, 2'd2, e);
        wr(A_PER, 32'd3, 2'd2, e);
        quiet(10, seen);
        chk("R7 new count does not restart", {31'b0, seen}, 0);
        wr(A_CTRL, 32'h1, 2'd2, e);
        wr(A_CTRL, 32'h3, 2'd2, e);
        wait_irq(n);
        chk("R7 re-arm expiry clocks", 32'(n), 3);

        // R6 auto-reload
        wr(A_CTRL, 32'h0, 2'd2, e);
        wr(A_SCL, 32'h1, 2'd2, e);
        wr(A_PER, 32'd7, 2'd2, e);
        wr(A_CTRL, 32'h7, 2'd2, e);
        wait_irq(n);
        chk("R6 first interval", 32'(n), 4);
        wait_irq(n);
        chk("R6 second interval", 32'(n), 4);
        wait_irq(n);
        chk("R6 third interval", 32'(n), 4);
        wr(A_CTRL, 32'h0, 2'd2, e);
        rd(A_CTRL, 2'd2, d, e);
        chk("R9 plain write clears flag", d, 0);

        // R10 count write while running
        wr(A_SCL, 32'h0, 2'd2, e);
        wr(A_PER, 32'd1000, 2'd2, e);
        wr(A_CTRL, 32'h3, 2'd2, e);
        repeat (5) @(negedge clk);
        wr(A_CNT, 32'd4, 2'd2, e);
        wait_irq(n);
        chk("R10 count write while running", 32'(n), 4);

        // R10 period write while running
        wr(A_CTRL, 32'h0, 2'd2, e);
        wr(A_PER, 32'd1000, 2'd2, e);
        wr(A_CTRL, 32'h3, 2'd2, e);
        repeat (5) @(negedge clk);
        wr(A_PER, 32'd6, 2'd2, e);
        wait_irq(n);
        chk("R10 period write while running", 32'(n), 6);

        // R13 scale change mid-run: 100 -> 88 remaining, then step 10
        wr(A_CTRL, 32'h0, 2'd2, e);
        wr(A_SCL, 32'h0, 2'd2, e);
        wr(A_PER, 32'd100, 2'd2, e);
        wr(A_CTRL, 32'h3, 2'd2, e);
        repeat (10) @(negedge clk);
        wr(A_SCL, 32'd9, 2'd2, e);
        wait_irq(n);
        chk("R13 scale change keeps remaining count", 32'(n), 9);

        // R3 upper scale bits ignored: 0x100 acts as step 1
        wr(A_CTRL, 32'h0, 2'd2, e);
        wr(A_SCL, 32'h100, 2'd2, e);
        wr(A_PER, 32'd6, 2'd2, e);
        wr(A_CTRL, 32'h3, 2'd2, e);
        wait_irq(n);
        chk("R3 scale bit 8 ignored", 32'(n), 6);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule